// File: doc/BRIEF.md
# E-paper Update Stage Sequencer

This block paces the staged refresh of an electrophoretic panel. A refresh moves through four stages. In every stage the same intermediate frame is written again and again, one line at a time. Frames keep repeating until that stage's time allowance, counted in millisecond ticks, has run out. The sequencer decides which stage is active and which line goes out next. It also marks where each frame begins and signals when the whole refresh has finished. It does not produce pixel data, drive the serial link or sequence power.

A host selects the panel geometry and pulses `start`. The sequencer then requests lines from a line-transmit engine through `line_req`, and the engine answers each line with `line_done`. A free-running millisecond tick feeds the stage timer. Because the block works to a time budget rather than a fixed count, the number of frames in a stage follows from how fast the engine returns lines. A frame that is under way when the budget runs out is always finished.

The controller has five states:
- `ST_IDLE` waits for `start`.
- `ST_FRAME` is a single cycle that opens a frame.
- `ST_LINE` requests lines until the last one is acknowledged.
- `ST_EOF` is a single decision cycle at the end of a frame.
- `ST_DONE` is a single completion cycle.

Its transitions are:
- IDLE→FRAME on `start`.
- FRAME→LINE always.
- LINE→EOF on the acknowledged last line.
- EOF→FRAME when the budget has not run out, or when it has run out before the last stage.
- EOF→DONE when the budget has run out in the last stage.
- DONE→IDLE always.

Top module: `epd_stage_seq`

## Requirements
- R1: Out of reset, and whenever idle, `line_req`, `frame_start`, `busy` and `done` are low, and `stage_idx` is 0 after reset.
- R2: A `start` seen while idle captures the geometry from `panel_sel`:
  - 0 or 1 gives 96 lines per frame and a 480 ms stage budget.
  - 2 or 3 gives 176 lines per frame and a 630 ms budget.
  - While busy, both `start` and `panel_sel` are ignored.
- R3: Each frame opens with a one-cycle `frame_start` pulse, which is followed by `line_req` held high. `line_num` reads 0 in the first `line_req` cycle and rises by one after each cycle in which `line_req` and `line_done` are both high, up to lines-1.
- R4: The stage timer counts `ms_tick` pulses seen while busy, starting from the stage's first frame. When a frame ends, the sequencer compares the count with the budget. At or above the budget, the next frame belongs to the next stage; below it, the same stage repeats.
- R5: A budget that runs out part-way through a frame does not cut the frame short. All lines up to lines-1 are still requested before the stage changes.
- R6: An update has exactly four stages, numbered 0 to 3. `stage_idx` changes only in a `frame_start` cycle.
- R7: `frame_count` counts the frames started in the current stage. It reads 1 from the cycle after the first `frame_start` of a stage and saturates at 255. It restarts on a stage change and on a new start.
- R8: When the budget has run out at the end of a frame in stage 3, `done` pulses for one cycle with `busy` low. The pulse comes two cycles after the last line's acknowledge. The block then returns to idle.
- R9: `busy` is high from the cycle after an accepted `start` until `done`. `line_req` and `frame_start` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an update (honoured only when idle) |
| panel_sel | input | 2 | Panel geometry select, captured at start |
| ms_tick | input | 1 | One-cycle pulse per elapsed millisecond |
| line_done | input | 1 | Line engine has accepted the requested line |
| line_req | output | 1 | Request transmission of line `line_num` |
| stage_idx | output | 2 | Current stage, 0 to 3 |
| line_num | output | 8 | Line index within the frame |
| frame_start | output | 1 | One-cycle pulse opening each frame |
| frame_count | output | 8 | Frames started in the current stage, saturating |
| busy | output | 1 | Update in progress |
| done | output | 1 | One-cycle pulse at update completion |

## Verification
Some rules are checked by the assertions on every cycle:
- Stage changes happen only on frame starts.
- Lines only step up by one.
- The frame counter never wraps.
- `line_req` and `frame_start` never overlap.
- The completion pulse is single and idle.

Other behaviours can only be shown by the bench's scenarios:
- How many frames each stage actually holds for a given tick rate.
- Whether the right geometry was captured.
- Whether a frame is completed after the budget expires mid-frame.
- Whether saturation is reached after hundreds of frames.
- Whether a mid-run restart attempt is ignored.

// File: rtl/epd_seq_pkg.sv
package epd_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FRAME,
        ST_LINE,
        ST_EOF,
        ST_DONE
    } seq_state_e;

endpackage

// File: rtl/epd_stage_timer.sv
module epd_stage_timer #(
    parameter int TMR_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             tick,
    input  logic [TMR_W-1:0] budget,
    output logic             expired
);
    logic [TMR_W-1:0] ms_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ms_q <= '0;
        end else if (clr) begin
            ms_q <= '0;
        end else if (tick && (ms_q != '1)) begin
            ms_q <= ms_q + 1'b1;
        end
    end

    assign expired = (ms_q >= budget);
endmodule

// File: rtl/epd_line_counter.sv
module epd_line_counter #(
    parameter int LINE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic [LINE_W-1:0] last_idx,
    output logic [LINE_W-1:0] line,
    output logic              at_last
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line <= '0;
        end else if (load) begin
            line <= '0;
        end else if (step && !at_last) begin
            line <= line + 1'b1;
        end
    end

    assign at_last = (line == last_idx);
endmodule

// File: rtl/epd_frame_counter.sv
module epd_frame_counter #(
    parameter int FCNT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              inc,
    output logic [FCNT_W-1:0] count
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clr) begin
            count <= '0;
        end else if (inc && (count != '1)) begin
            count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/epd_stage_seq.sv
module epd_stage_seq
    import epd_seq_pkg::*;
#(
    parameter int N_STAGES        = 4,
    parameter int LINES_SMALL     = 96,
    parameter int LINES_LARGE     = 176,
    parameter int BUDGET_SMALL_MS = 480,
    parameter int BUDGET_LARGE_MS = 630,
    parameter int FCNT_W          = 8,
    parameter int STAGE_W         = $clog2(N_STAGES),
    parameter int LINE_W          = $clog2(LINES_LARGE)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [1:0]         panel_sel,
    input  logic               ms_tick,
    input  logic               line_done,
    output logic               line_req,
    output logic [STAGE_W-1:0] stage_idx,
    output logic [LINE_W-1:0]  line_num,
    output logic               frame_start,
    output logic [FCNT_W-1:0]  frame_count,
    output logic               busy,
    output logic               done
);
    localparam int TMR_W = $clog2(BUDGET_LARGE_MS + 1);
    localparam logic [STAGE_W-1:0] LAST_STAGE = STAGE_W'(N_STAGES - 1);

    seq_state_e state_q, state_d;

    logic [LINE_W-1:0] last_idx_q;
    logic [TMR_W-1:0]  budget_q;
    logic [STAGE_W-1:0] stage_q;

    logic accept, advance, expired, at_last;

    assign accept  = (state_q == ST_IDLE) && start;
    assign advance = (state_q == ST_EOF) && expired && (stage_q != LAST_STAGE);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = ST_FRAME;
            ST_FRAME: state_d = ST_LINE;
            ST_LINE:  if (line_done && at_last) state_d = ST_EOF;
            ST_EOF: begin
                if (expired && (stage_q == LAST_STAGE)) state_d = ST_DONE;
                else                                    state_d = ST_FRAME;
            end
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register and per-update context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            stage_q    <= '0;
            last_idx_q <= LINE_W'(LINES_SMALL - 1);
            budget_q   <= TMR_W'(BUDGET_SMALL_MS);
        end else begin
            state_q <= state_d;
            if (accept) begin
                stage_q <= '0;
                if (panel_sel[1]) begin
                    last_idx_q <= LINE_W'(LINES_LARGE - 1);
                    budget_q   <= TMR_W'(BUDGET_LARGE_MS);
                end else begin
                    last_idx_q <= LINE_W'(LINES_SMALL - 1);
                    budget_q   <= TMR_W'(BUDGET_SMALL_MS);
                end
            end else if (advance) begin
                stage_q <= stage_q + 1'b1;
            end
        end
    end

    // Moore outputs
    always_comb begin
        frame_start = (state_q == ST_FRAME);
        line_req    = (state_q == ST_LINE);
        busy        = (state_q == ST_FRAME) || (state_q == ST_LINE) || (state_q == ST_EOF);
        done        = (state_q == ST_DONE);
    end

    assign stage_idx = stage_q;

    epd_stage_timer #(.TMR_W(TMR_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (accept || advance),
        .tick    (ms_tick && busy),
        .budget  (budget_q),
        .expired (expired)
    );

    epd_line_counter #(.LINE_W(LINE_W)) u_lines (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (state_q == ST_FRAME),
        .step     ((state_q == ST_LINE) && line_done),
        .last_idx (last_idx_q),
        .line     (line_num),
        .at_last  (at_last)
    );

    epd_frame_counter #(.FCNT_W(FCNT_W)) u_frames (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (accept || advance),
        .inc   (state_q == ST_FRAME),
        .count (frame_count)
    );
endmodule

// File: rtl/epd_stage_seq_chk.sv
module epd_stage_seq_chk #(
    parameter int STAGE_W     = 2,
    parameter int LINE_W      = 8,
    parameter int FCNT_W      = 8,
    parameter int LINES_LARGE = 176
) (
    input logic               clk,
    input logic               rst_n,
    input logic               line_req,
    input logic               line_done,
    input logic [STAGE_W-1:0] stage_idx,
    input logic [LINE_W-1:0]  line_num,
    input logic               frame_start,
    input logic [FCNT_W-1:0]  frame_count,
    input logic               busy,
    input logic               done
);
    // R6: the stage only moves in a frame-start cycle
    a_r6_stage_moves_on_frame: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(stage_idx) |-> frame_start);

    // R3: acknowledged line steps by exactly one, or the frame closes
    a_r3_line_step: assert property (@(posedge clk) disable iff (!rst_n)
        (line_req && line_done) |=> (!line_req || (line_num == LINE_W'($past(line_num) + 1'b1))));

    // R3: requested line stays inside the largest frame
    a_r3_line_bound: assert property (@(posedge clk) disable iff (!rst_n)
        line_req |-> (int'(line_num) < LINES_LARGE));

    // R7: saturated frame count holds or restarts, never wraps upward
    a_r7_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_count == '1) |=> ((frame_count == '1) || (frame_count == '0)));

    // R8: completion is a single idle cycle
    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && !line_req) ##1 !done);

    // R9: request and frame opening never overlap; requests only while busy
    a_r9_req_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(line_req && frame_start));

    a_r9_req_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (line_req || frame_start) |-> busy);
endmodule

bind epd_stage_seq epd_stage_seq_chk #(
    .STAGE_W     (STAGE_W),
    .LINE_W      (LINE_W),
    .FCNT_W      (FCNT_W),
    .LINES_LARGE (LINES_LARGE)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .line_req    (line_req),
    .line_done   (line_done),
    .stage_idx   (stage_idx),
    .line_num    (line_num),
    .frame_start (frame_start),
    .frame_count (frame_count),
    .busy        (busy),
    .done        (done)
);

// File: tb/epd_stage_seq_bench.sv
module epd_stage_seq_bench;

    typedef struct {
        bit kind_done;
        int stage;
        int fcnt;
    } exp_item_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [1:0] panel_sel = 2'd0;
    logic       ms_tick = 1'b0;
    logic       line_done = 1'b0;
    logic       line_req, frame_start, busy, done;
    logic [1:0] stage_idx;
    logic [7:0] line_num, frame_count;

    always #2.5 clk = ~clk;

    epd_stage_seq u_epd_stage_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .panel_sel   (panel_sel),
        .ms_tick     (ms_tick),
        .line_done   (line_done),
        .line_req    (line_req),
        .stage_idx   (stage_idx),
        .line_num    (line_num),
        .frame_start (frame_start),
        .frame_count (frame_count),
        .busy        (busy),
        .done        (done)
    );

    int n_vec = 0;
    int n_bad = 0;
    exp_item_t exp_q[$];

    int  exp_lines   = 96;
    int  exp_budget  = 480;
    int  exp_line    = 0;
    int  stage_ticks = 0;
    int  cur_stage   = 0;
    int  frames_in   = 0;
    int  tick_mode   = 0;
    bit  run_over    = 1'b0;
    bit  timed_out   = 1'b0;
    bit  fc_pending  = 1'b0;
    int  fc_expect   = 0;
    int  cycles      = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // reference: expected outcome of each frame boundary, pushed by the driver side
    task automatic push_frame(input int stg, input int fc);
        exp_item_t it;
        it.kind_done = 1'b0;
        it.stage     = stg;
        it.fcnt      = (fc > 255) ? 255 : fc;
        exp_q.push_back(it);
    endtask

    task automatic push_done();
        exp_item_t it;
        it.kind_done = 1'b1;
        it.stage     = 3;
        it.fcnt      = 0;
        exp_q.push_back(it);
    endtask

    // watchdog
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == 150000 && !timed_out) begin
            timed_out <= 1'b1;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 0);
        end
    end

    // monitor: pops expected items as the design opens frames or completes
    always @(negedge clk) begin
        if (rst_n) begin
            if (fc_pending) begin
                check(frame_count == 8'(fc_expect), "R7 frame_count", frame_count, fc_expect);
                fc_pending = 1'b0;
            end
            if (frame_start) begin
                check(!line_req, "R9 req/frame_start overlap", line_req, 0);
                if (exp_q.size() == 0) begin
                    check(1'b0, "R4 unexpected frame_start", 1, 0);
                end else begin
                    exp_item_t it;
                    it = exp_q.pop_front();
                    check(!it.kind_done, "R8 frame instead of done", 1, 0);
                    check(int'(stage_idx) == it.stage, "R4/R6 stage_idx", stage_idx, it.stage);
                    fc_pending = 1'b1;
                    fc_expect  = it.fcnt;
                end
            end
            if (done) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R8 unexpected done", 1, 0);
                end else begin
                    exp_item_t it;
                    it = exp_q.pop_front();
                    check(it.kind_done, "R8 done too early", 0, 1);
                end
                check(!busy, "R8 busy during done", busy, 0);
                check(stage_idx == 2'd3, "R6 final stage", stage_idx, 3);
                run_over = 1'b1;
            end
        end
    end

    // line engine model with tick injection
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && line_req) begin
                check(int'(line_num) == exp_line, "R3 line_num", line_num, exp_line);
                check(busy, "R9 busy while requesting", busy, 1);
                for (int k = 0; k < tick_mode; k++) begin
                    ms_tick = 1'b1;
                    @(negedge clk);
                    ms_tick = 1'b0;
                    stage_ticks++;
                end
                line_done = 1'b1;
                @(negedge clk);
                line_done = 1'b0;
                if (exp_line == exp_lines - 1) begin
                    exp_line = 0;
                    if (stage_ticks >= exp_budget) begin
                        if (cur_stage == 3) begin
                            push_done();
                        end else begin
                            cur_stage++;
                            frames_in   = 1;
                            stage_ticks = 0;
                            push_frame(cur_stage, frames_in);
                        end
                    end else begin
                        frames_in++;
                        push_frame(cur_stage, frames_in);
                    end
                end else begin
                    exp_line++;
                end
            end
        end
    end

    task automatic launch(input logic [1:0] sel, input int mode);
        @(negedge clk);
        panel_sel   = sel;
        exp_lines   = sel[1] ? 176 : 96;
        exp_budget  = sel[1] ? 630 : 480;
        tick_mode   = mode;
        cur_stage   = 0;
        frames_in   = 1;
        stage_ticks = 0;
        exp_line    = 0;
        run_over    = 1'b0;
        push_frame(0, 1);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy, "R9 busy after start", busy, 1);
    endtask

    task automatic finish_run();
        wait (run_over || timed_out);
        @(negedge clk);
        check(!busy && !line_req && !frame_start && !done, "R8 back to idle",
              {busy, line_req, frame_start, done}, 0);
        check(exp_q.size() == 0, "R4 leftover expectations", exp_q.size(), 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        check(!line_req && !frame_start && !busy && !done, "R1 reset outputs",
              {line_req, frame_start, busy, done}, 0);
        check(stage_idx == 2'd0, "R1 reset stage", stage_idx, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(!busy && !line_req, "R1 idle without start", {busy, line_req}, 0);

        // small panel, one tick per line: budget lands exactly on a frame end (R4)
        launch(2'd0, 1);
        // R2: restart and geometry change while busy must be ignored
        wait (cur_stage == 1 && frames_in == 3);
        @(negedge clk);
        start = 1'b1;
        panel_sel = 2'd2;
        @(negedge clk);
        start = 1'b0;
        finish_run();

        // large panel, two ticks per line: budget expires mid-frame (R5)
        if (!timed_out) launch(2'd3, 2);
        finish_run();

        // panel select 1, no ticks for 260 frames: frame counter saturates (R7)
        if (!timed_out) launch(2'd1, 0);
        wait ((cur_stage == 0 && frames_in >= 260) || timed_out);
        tick_mode = 2;
        finish_run();

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule